// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block is a master-only serial engine for short links to simple shift-register peripherals. It drives a shift clock on one output pin and moves 8-bit words over a single data pin. That pin is driven outward during a transmit and is released to the peripheral during a receive. The shift clock runs at the system clock divided by 12 or by 4, chosen by a select bit that is captured when each transfer begins. Between transfers the shift clock rests high.

A write to the buffer port starts a transmit. Each bit is placed on the data pin one system clock before the shift clock falls, so the peripheral can capture it on the following rising edge. A receive starts on its own whenever receiving is enabled and the receive flag is clear. The engine samples the data pin on each rising shift-clock edge and stores the word in the read buffer. The receive flag then rises, and no further word is shifted in until software clears that flag.

Top module: `sync_shift_port`

## Requirements
- R1: Every shift-clock period is 12 system clocks when `div_sel` is 0 and 4 when it is 1. The clock is low for the first half of each period and high for the second half.
- R2: A transmitted word leaves on `sdata_o` least significant bit first. It is valid at each rising shift-clock edge.
- R3: Each transmit bit, including the first, appears on `sdata_o` exactly one system clock before a falling shift-clock edge.
- R4: Every transfer has exactly 8 falling shift-clock edges. The shift clock is high whenever no transfer is in progress.
- R5: A buffer write that arrives while a transfer is in progress is ignored. It causes no second transmit and does not alter the word on the pin.
- R6: `tx_flag` rises once the eighth bit period ends. At that point `sdata_oe` is already low.
- R7: A receive starts only when `rx_en` is 1 and `rx_flag` is 0. While `rx_en` is 0, the shift clock stays idle.
- R8: During a receive, `sdata_i` is sampled at each rising shift-clock edge, least significant bit first. The word appears on `buf_rdata` when `rx_flag` rises.
- R9: `rx_flag` rises one system clock after the last rising shift-clock edge of a receive.
- R10: While `rx_flag` is 1, no receive starts. Clearing the flag lets the next receive begin.
- R11: If a buffer write and the receive start condition occur in the same idle cycle, the transmit wins. The receive may start after the transmit completes.
- R12: `rx_flag_clr` and `tx_flag_clr` each clear their flag on the next clock. If a flag is set and cleared in the same cycle, the set wins.
- R13: While `rst_n` is low at a clock edge, both flags clear, the shift clock goes high and `sdata_oe` goes low.
- R14: `sdata_oe` is high only during a transmit. It stays low during a receive and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_sel | input | 1 | Shift-clock divider select: 0 divides by 12, 1 divides by 4 |
| buf_wr | input | 1 | Buffer write strobe; starts a transmit when idle |
| buf_wdata | input | DATA_W | Word to transmit |
| buf_rdata | output | DATA_W | Last received word |
| rx_en | input | 1 | Receive enable |
| rx_flag_clr | input | 1 | Clears the receive flag |
| tx_flag_clr | input | 1 | Clears the transmit flag |
| rx_flag | output | 1 | A received word is waiting |
| tx_flag | output | 1 | A transmit has completed |
| sdata_i | input | 1 | Data pin input value |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock pin |

## Verification
Two events can land on the same idle clock edge. One is a buffer write. The other is the receive start condition, meaning `rx_en` high and `rx_flag` low. The bench raises `rx_en` and `buf_wr` together. It then judges the result by two signs: `sdata_oe` is high in the very next cycle, and the scoreboard sees the transmitted word before the received one. A second collision is a flag set against a flag clear. It is provoked by holding `rx_flag_clr` high through a whole receive. The check expects `rx_flag` to be high for one cycle, with the word loaded, before the clear takes effect.

// File: rtl/ssp_pkg.sv
// Package: shared types for the synchronous shift port.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } ssp_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } ssp_dir_e;
endpackage

// File: rtl/ssp_seq.sv
// Module: ssp_seq
// Transfer sequencer. It counts the system-clock phases within each shift
// period and the bits within each word, and it drives the shift clock. It
// also issues strobes to the datapath: start, advance the transmit bit,
// sample, and done.
// Assumes: SLOW_DIV and FAST_DIV are even and at least 4; the divider
// select is captured when each transfer starts.
module ssp_seq
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    input  logic tx_req,
    input  logic rx_ok,
    output logic busy,
    output logic rx_active,
    output logic sclk,
    output logic go_tx,
    output logic adv_tx,
    output logic samp,
    output logic tx_done,
    output logic rx_done
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PH_W    = $clog2(MAX_DIV);
    localparam int BC_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [PH_W-1:0] S_LAST = PH_W'(SLOW_DIV - 1);
    localparam logic [PH_W-1:0] S_PREV = PH_W'(SLOW_DIV - 2);
    localparam logic [PH_W-1:0] S_HALF = PH_W'(SLOW_DIV / 2);
    localparam logic [PH_W-1:0] F_LAST = PH_W'(FAST_DIV - 1);
    localparam logic [PH_W-1:0] F_PREV = PH_W'(FAST_DIV - 2);
    localparam logic [PH_W-1:0] F_HALF = PH_W'(FAST_DIV / 2);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    ssp_state_e      st;
    ssp_dir_e        dir;
    logic            fast;
    logic [PH_W-1:0] phase;
    logic [BC_W-1:0] bitcnt;
    logic            sclk_q;
    logic [PH_W-1:0] ph_last, ph_prev, ph_half;
    logic            in_shift, go_rx;

    // Per-transfer phase landmarks, chosen by the divider captured at start.
    always_comb begin
        ph_last = fast ? F_LAST : S_LAST;
        ph_prev = fast ? F_PREV : S_PREV;
        ph_half = fast ? F_HALF : S_HALF;
    end

    // Start decisions and the strobes sent to the datapath.
    always_comb begin
        in_shift = (st == ST_SHIFT);
        go_tx    = (st == ST_IDLE) && tx_req;
        go_rx    = (st == ST_IDLE) && !tx_req && rx_ok;
        adv_tx   = in_shift && (dir == DIR_TX) && (phase == ph_prev) && (bitcnt != LAST_BIT);
        samp     = in_shift && (dir == DIR_RX) && (phase == ph_half - 1'b1);
        rx_done  = in_shift && (dir == DIR_RX) && (phase == ph_half) && (bitcnt == LAST_BIT);
        tx_done  = in_shift && (dir == DIR_TX) && (phase == ph_last) && (bitcnt == LAST_BIT);
    end

    // Sequencer state, phase and bit counters, and the shift-clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            dir    <= DIR_TX;
            fast   <= 1'b0;
            phase  <= '0;
            bitcnt <= '0;
            sclk_q <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    sclk_q <= 1'b1;
                    if (go_tx || go_rx) begin
                        st   <= ST_LEAD;
                        dir  <= go_tx ? DIR_TX : DIR_RX;
                        fast <= div_sel;
                    end
                end
                ST_LEAD: begin
                    st     <= ST_SHIFT;
                    phase  <= '0;
                    bitcnt <= '0;
                    sclk_q <= 1'b0;
                end
                default: begin
                    if (tx_done || rx_done) begin
                        st     <= ST_IDLE;
                        sclk_q <= 1'b1;
                    end else if (phase == ph_last) begin
                        phase  <= '0;
                        bitcnt <= bitcnt + 1'b1;
                        sclk_q <= 1'b0;
                    end else begin
                        phase <= phase + 1'b1;
                        if (phase == ph_half - 1'b1) begin
                            sclk_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign rx_active = busy && (dir == DIR_RX);
    assign sclk      = sclk_q;

    // R1: every rising shift-clock edge falls at mid-period.
    assert_rise_mid_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> (phase == ph_half));
endmodule

// File: rtl/ssp_shift.sv
// Module: ssp_shift
// Data path. It holds the transmit shift register, which drives the data pin
// least significant bit first, and the receive shift register, which fills
// from the most significant end so that the first bit received ends in bit 0.
// Assumes: the strobes come from ssp_seq and are mutually consistent.
module ssp_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_tx,
    input  logic              adv_tx,
    input  logic              tx_done,
    input  logic              samp,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sdi,
    output logic              sdo,
    output logic              oe,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] txsh;
    logic [DATA_W-1:0] rxsh;

    // Transmit side: load the word, present one bit at a time, release the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsh <= '0;
            sdo  <= 1'b0;
            oe   <= 1'b0;
        end else if (go_tx) begin
            txsh <= wdata;
            sdo  <= wdata[0];
            oe   <= 1'b1;
        end else if (adv_tx) begin
            txsh <= txsh >> 1;
            sdo  <= txsh[1];
        end else if (tx_done) begin
            oe   <= 1'b0;
        end
    end

    // Receive side: capture the pin at each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsh <= '0;
        end else if (samp) begin
            rxsh <= {sdi, rxsh[DATA_W-1:1]};
        end
    end

    assign rx_word = rxsh;
endmodule

// File: rtl/sync_shift_port.sv
// Module: sync_shift_port
// Top of the master synchronous half-duplex shift port. It combines the
// sequencer and the data path, holds the receive buffer and the two flags,
// and gates receive starts on enable and flag state.
// Assumes: one data pin, driven only while sdata_oe is high.
module sync_shift_port #(
    parameter int DATA_W   = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              rx_en,
    input  logic              rx_flag_clr,
    input  logic              tx_flag_clr,
    output logic              rx_flag,
    output logic              tx_flag,
    input  logic              sdata_i,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic              sclk_o
);
    logic busy, rx_active, go_tx, adv_tx, samp, tx_done, rx_done;
    logic [DATA_W-1:0] rx_word;
    logic rx_ok;

    assign rx_ok = rx_en && !rx_flag;

    ssp_seq #(.DATA_W(DATA_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .tx_req   (buf_wr),
        .rx_ok    (rx_ok),
        .busy     (busy),
        .rx_active(rx_active),
        .sclk     (sclk_o),
        .go_tx    (go_tx),
        .adv_tx   (adv_tx),
        .samp     (samp),
        .tx_done  (tx_done),
        .rx_done  (rx_done)
    );

    ssp_shift #(.DATA_W(DATA_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_tx  (go_tx),
        .adv_tx (adv_tx),
        .tx_done(tx_done),
        .samp   (samp),
        .wdata  (buf_wdata),
        .sdi    (sdata_i),
        .sdo    (sdata_o),
        .oe     (sdata_oe),
        .rx_word(rx_word)
    );

    // Receive buffer and receive flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flag   <= 1'b0;
            buf_rdata <= '0;
        end else if (rx_done) begin
            rx_flag   <= 1'b1;
            buf_rdata <= rx_word;
        end else if (rx_flag_clr) begin
            rx_flag   <= 1'b0;
        end
    end

    // Transmit flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
        end else if (tx_done) begin
            tx_flag <= 1'b1;
        end else if (tx_flag_clr) begin
            tx_flag <= 1'b0;
        end
    end

    // R3: a new transmit bit on the pin is followed by a falling shift-clock edge.
    assert_bit_before_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && (sdata_o != $past(sdata_o))) |=> !sclk_o);

    // R4: the shift clock rests high when the engine is idle.
    assert_idle_clock_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o);

    // R6: the pin is released by the time the transmit flag rises.
    assert_pin_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> !sdata_oe);

    // R9: the receive flag rises one clock after a rising shift-clock edge.
    assert_rxflag_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> ($past(sclk_o) && !$past(sclk_o, 2)));

    // R10: with the receive flag up and no write, an idle engine stays idle.
    assert_stall_on_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rx_flag && !buf_wr) |=> !busy);

    // R14: the pin is never driven while receiving.
    assert_no_drive_in_rx_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> !sdata_oe);
endmodule

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       div_sel;
    logic       buf_wr;
    logic [7:0] buf_wdata;
    logic [7:0] buf_rdata;
    logic       rx_en, rx_flag_clr, tx_flag_clr;
    logic       rx_flag, tx_flag;
    logic       sdata_i;
    logic       sdata_o, sdata_oe, sclk_o;

    int n_chk = 0;
    int n_bad = 0;
    int cur_div = 12;
    bit rx_mode = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] slv_q[$];
    int rise_cnt = 0;
    int txf_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_shift_port dut_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .rx_en(rx_en),
        .rx_flag_clr(rx_flag_clr), .tx_flag_clr(tx_flag_clr),
        .rx_flag(rx_flag), .tx_flag(tx_flag), .sdata_i(sdata_i),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sclk_o(sclk_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor and scoreboard: sample away from the active edge.
    bit prev_sclk, prev_oe, prev_sdo, prev_txf, prev_rxf, pend_fall;
    int since_rise, low_run, rises_x, falls, txb, rxb;
    logic [7:0] txw, cur_slv, exp_b;
    always @(negedge clk) begin
        if (rst_n !== 1'b1) begin
            prev_sclk = 1; prev_oe = 0; prev_sdo = 0; prev_txf = 0; prev_rxf = 0;
            pend_fall = 0; since_rise = 0; low_run = 0; rises_x = 0; falls = 0;
            txb = 0; rxb = 0; txw = 0; cur_slv = 0; sdata_i = 1'b1;
        end else begin
            since_rise++;
            if (!sclk_o) low_run++;
            if (pend_fall) begin
                chk(!sclk_o, "R3 fall after bit", int'(sclk_o), 0);
                pend_fall = 0;
            end
            if (sclk_o && !prev_sclk) begin
                chk(low_run == cur_div / 2, "R1 low half", low_run, cur_div / 2);
                if (rises_x > 0) chk(since_rise == cur_div, "R1 period", since_rise, cur_div);
                rises_x++; rise_cnt++; since_rise = 0; low_run = 0;
                if (sdata_oe) begin
                    txw = {sdata_o, txw[7:1]};
                    txb++;
                    if (txb == 8) begin
                        txb = 0;
                        if (tx_q.size() == 0) chk(0, "R2 unexpected tx", int'(txw), -1);
                        else begin
                            exp_b = tx_q.pop_front();
                            chk(txw == exp_b, "R2 tx word", int'(txw), int'(exp_b));
                        end
                    end
                end
            end
            if (!sclk_o && prev_sclk) begin
                falls++;
                if (rx_mode) chk(!sdata_oe, "R14 no drive in rx", int'(sdata_oe), 0);
                if (!sdata_oe) begin
                    if (rxb == 0) cur_slv = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
                    sdata_i = cur_slv[rxb];
                    rxb = (rxb + 1) % 8;
                end
            end
            if (sdata_oe && (!prev_oe || sdata_o != prev_sdo)) pend_fall = 1;
            if (tx_flag && !prev_txf) begin
                chk(falls == 8, "R4 falls per tx", falls, 8);
                chk(!sdata_oe, "R6 pin released", int'(sdata_oe), 0);
                chk(sclk_o, "R4 clock high after tx", int'(sclk_o), 1);
                falls = 0; rises_x = 0; txf_cnt++;
            end
            if (rx_flag && !prev_rxf) begin
                chk(since_rise == 1, "R9 flag delay", since_rise, 1);
                chk(falls == 8, "R4 falls per rx", falls, 8);
                if (rx_q.size() == 0) chk(0, "R8 unexpected rx", int'(buf_rdata), -1);
                else begin
                    exp_b = rx_q.pop_front();
                    chk(buf_rdata == exp_b, "R8 rx word", int'(buf_rdata), int'(exp_b));
                end
                falls = 0; rises_x = 0;
            end
            prev_sclk = sclk_o; prev_oe = sdata_oe; prev_sdo = sdata_o;
            prev_txf = tx_flag; prev_rxf = rx_flag;
        end
    end

    task automatic send(input logic [7:0] b, input bit expect_it);
        @(negedge clk);
        buf_wdata = b; buf_wr = 1'b1;
        if (expect_it) tx_q.push_back(b);
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (tx_flag) return;
        end
        chk(0, "R6 tx flag timeout", 0, 1);
    endtask

    task automatic wait_rx();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (rx_flag) return;
        end
        chk(0, "R8 rx flag timeout", 0, 1);
    endtask

    task automatic clr_tx();
        @(negedge clk); tx_flag_clr = 1'b1;
        @(negedge clk); tx_flag_clr = 1'b0; #1;
        chk(!tx_flag, "R12 tx clear", int'(tx_flag), 0);
    endtask

    task automatic clr_rx();
        @(negedge clk); rx_flag_clr = 1'b1;
        @(negedge clk); rx_flag_clr = 1'b0; #1;
        chk(!rx_flag, "R12 rx clear", int'(rx_flag), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            summary();
            $finish;
        end
    end

    initial begin
        int r0, t0;
        rst_n = 0; div_sel = 0; buf_wr = 0; buf_wdata = 0;
        rx_en = 0; rx_flag_clr = 0; tx_flag_clr = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!rx_flag, "R13 rx flag reset", int'(rx_flag), 0);
        chk(!tx_flag, "R13 tx flag reset", int'(tx_flag), 0);
        chk(sclk_o, "R13 clock high", int'(sclk_o), 1);
        chk(!sdata_oe, "R13 pin released", int'(sdata_oe), 0);
        @(negedge clk); rst_n = 1;

        // R2/R1: slow transmit
        div_sel = 0; cur_div = 12;
        send(8'hA5, 1); wait_tx(); clr_tx();
        // R2/R1: fast transmit
        div_sel = 1; cur_div = 4;
        send(8'h3C, 1); wait_tx(); clr_tx();

        // R5: write during a transfer is ignored
        t0 = txf_cnt;
        send(8'h81, 1);
        repeat (5) @(negedge clk);
        send(8'hFF, 0);
        wait_tx(); clr_tx();
        repeat (60) @(negedge clk); #1;
        chk(txf_cnt == t0 + 1, "R5 single transmit", txf_cnt - t0, 1);
        chk(!sdata_oe && !tx_flag, "R5 no extra transfer", int'(sdata_oe), 0);

        // R7/R8/R10: slow receive with stall
        rx_mode = 1; div_sel = 0; cur_div = 12;
        slv_q.push_back(8'h96); rx_q.push_back(8'h96);
        @(negedge clk); rx_en = 1;
        wait_rx();
        r0 = rise_cnt;
        repeat (80) @(negedge clk); #1;
        chk(rise_cnt == r0, "R10 stalled while flag set", rise_cnt - r0, 0);
        chk(rx_flag, "R10 flag held", int'(rx_flag), 1);
        slv_q.push_back(8'h0F); rx_q.push_back(8'h0F);
        clr_rx();
        wait_rx();
        @(negedge clk); rx_en = 0;
        clr_rx();
        r0 = rise_cnt;
        repeat (40) @(negedge clk); #1;
        chk(rise_cnt == r0, "R7 idle with rx_en low", rise_cnt - r0, 0);

        // R8: fast receive
        div_sel = 1; cur_div = 4;
        slv_q.push_back(8'hE7); rx_q.push_back(8'hE7);
        @(negedge clk); rx_en = 1;
        wait_rx();
        @(negedge clk); rx_en = 0;
        clr_rx();
        rx_mode = 0;

        // R11: write and receive start in the same cycle
        tx_q.push_back(8'hC3);
        slv_q.push_back(8'h5A); rx_q.push_back(8'h5A);
        @(negedge clk);
        rx_en = 1; buf_wdata = 8'hC3; buf_wr = 1;
        @(negedge clk); buf_wr = 0; #1;
        chk(sdata_oe, "R11 transmit wins", int'(sdata_oe), 1);
        wait_tx();
        wait_rx();
        @(negedge clk); rx_en = 0;
        clr_tx(); clr_rx();

        // R12: set beats clear when clear is held through a receive
        rx_mode = 1;
        slv_q.push_back(8'h24); rx_q.push_back(8'h24);
        @(negedge clk); rx_flag_clr = 1; rx_en = 1;
        wait_rx();
        chk(rx_flag, "R12 set wins over clear", int'(rx_flag), 1);
        rx_en = 0;
        @(negedge clk); #1;
        chk(!rx_flag, "R12 clear after set", int'(rx_flag), 0);
        rx_flag_clr = 0;
        rx_mode = 0;

        repeat (20) @(negedge clk); #1;
        chk(tx_q.size() == 0, "R2 tx queue drained", tx_q.size(), 0);
        chk(rx_q.size() == 0, "R8 rx queue drained", rx_q.size(), 0);
        chk(sclk_o, "R4 clock idle high at end", int'(sclk_o), 1);
        done = 1;
        summary();
        $finish;
    end
endmodule